// File: doc/BRIEF.md
# Bit-Matrix Multiply Unit

This unit reads each of its two wide operands as a square bit matrix and produces one of three results: the transpose of the first operand, the Boolean (OR of ANDs) product of the two matrices, or their GF(2) product, where each result bit is the XOR of the AND terms. With the default dimension of 8, each operand is a 64-bit word that holds an 8x8 matrix. Both products work on the transpose of the second operand. Each result bit then comes from one row of the first operand and one row of that transposed copy, so no column has to be gathered when the bit is computed.

The logic is fully combinational up to a single output register. A select code and two operands go in on one rising edge, and the result appears on the output one cycle later. A new operation can start on every cycle. The matrix dimension is a parameter, and the two product kinds are built from one reduction core that a generate-time option sets to OR or to XOR.

Top module: `bitmat_unit`

## Requirements
- R1: Row r of a matrix is the DIM-bit slice starting at bit r*DIM of the word, and column c of that row is bit r*DIM+c. The select codes are 0 for transpose, 1 for the OR product and 2 for the XOR product.
- R2: With select 0, result bit c*DIM+r equals bit r*DIM+c of operand A for every r and c.
- R3: With select 1, result bit r*DIM+c is 1 exactly when some k has both A bit r*DIM+k and B bit k*DIM+c set.
- R4: With select 2, result bit r*DIM+c is the parity of the count of k for which A bit r*DIM+k and B bit k*DIM+c are both set. An even count, including a full row meeting a full column, gives 0.
- R5: Select code 3 gives an all-zero result, whatever the operands are.
- R6: The result is registered. It reflects the select and operands sampled on the previous rising edge, and it reads zero while reset (active low) is held.
- R7: When A is the identity matrix (the diagonal bits i*DIM+i set), both products return B unchanged.
- R8: With select 0, operand B has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the result register |
| op_sel | input | 2 | Operation select: 0 transpose, 1 OR product, 2 XOR product, 3 zero |
| opnd_a | input | DIM*DIM | First matrix (rows for products, source for transpose) |
| opnd_b | input | DIM*DIM | Second matrix (transposed internally for products) |
| result | output | DIM*DIM | Registered result matrix |

## Verification
The transpose of B and the OR or XOR reduction both feed the same product in one cycle, and the operation select can change on every cycle. The bench therefore drives a new select and new operands at every falling edge and cycles through all four codes without any idle gap. It checks each registered result against a loop-based reference that indexes rows and columns directly. Patterns that make the two products differ, such as a full row against a full column, where OR gives 1 and XOR gives 0, show whether the reduction or the internal transpose is wired wrongly.

// File: rtl/bmm_pkg.sv
package bmm_pkg;
   typedef enum logic [1:0] {
      BMM_FLIP = 2'd0,
      BMM_OR   = 2'd1,
      BMM_XOR  = 2'd2,
      BMM_RSVD = 2'd3
   } bmm_op_e;
endpackage

// File: rtl/bmm_transpose.sv
module bmm_transpose #(
   parameter int DIM = 8
) (
   input  logic [DIM*DIM-1:0] mat_in,
   output logic [DIM*DIM-1:0] mat_out
);
   for (genvar r = 0; r < DIM; r++) begin : g_row
      for (genvar c = 0; c < DIM; c++) begin : g_col
         assign mat_out[c*DIM+r] = mat_in[r*DIM+c];
      end
   end
endmodule

// File: rtl/bmm_product.sv
module bmm_product #(
   parameter int DIM     = 8,
   parameter bit USE_XOR = 1'b0
) (
   input  logic [DIM*DIM-1:0] rows_a,
   input  logic [DIM*DIM-1:0] rows_bt,
   output logic [DIM*DIM-1:0] prod
);
   for (genvar r = 0; r < DIM; r++) begin : g_row
      for (genvar c = 0; c < DIM; c++) begin : g_col
         logic [DIM-1:0] hit;
         assign hit = rows_a[r*DIM +: DIM] & rows_bt[c*DIM +: DIM];
         if (USE_XOR) begin : g_par
            assign prod[r*DIM+c] = ^hit;
         end else begin : g_any
            assign prod[r*DIM+c] = |hit;
         end
      end
   end
endmodule

// File: rtl/bitmat_unit.sv
module bitmat_unit #(
   parameter int DIM = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           op_sel,
   input  logic [DIM*DIM-1:0]   opnd_a,
   input  logic [DIM*DIM-1:0]   opnd_b,
   output logic [DIM*DIM-1:0]   result
);
   import bmm_pkg::*;

   localparam int W = DIM * DIM;

   if (DIM < 2) begin : g_bad_dim
      $error("bitmat_unit: DIM must be at least 2");
   end

   logic [W-1:0] a_t, b_t, p_or, p_xor;
   logic [W-1:0] nxt;
   bmm_op_e      op;

   assign op = bmm_op_e'(op_sel);

   bmm_transpose #(.DIM(DIM)) i_flip_a (.mat_in(opnd_a), .mat_out(a_t));
   bmm_transpose #(.DIM(DIM)) i_flip_b (.mat_in(opnd_b), .mat_out(b_t));

   bmm_product #(.DIM(DIM), .USE_XOR(1'b0)) i_or  (.rows_a(opnd_a), .rows_bt(b_t), .prod(p_or));
   bmm_product #(.DIM(DIM), .USE_XOR(1'b1)) i_xor (.rows_a(opnd_a), .rows_bt(b_t), .prod(p_xor));

   always_comb begin
      case (op)
         BMM_FLIP: nxt = a_t;
         BMM_OR:   nxt = p_or;
         BMM_XOR:  nxt = p_xor;
         default:  nxt = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) result <= '0;
      else        result <= nxt;
   end
endmodule

// File: rtl/bitmat_unit_chk.sv
module bitmat_unit_chk #(
   parameter int DIM = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [1:0]           op_sel,
   input logic [DIM*DIM-1:0]   opnd_a,
   input logic [DIM*DIM-1:0]   opnd_b,
   input logic [DIM*DIM-1:0]   result
);
   localparam int W = DIM * DIM;

   function automatic logic [W-1:0] ident();
      logic [W-1:0] m = '0;
      for (int k = 0; k < DIM; k++) m[k*DIM+k] = 1'b1;
      return m;
   endfunction

   localparam logic [W-1:0] IDENT = ident();

   // R6
   reset_zero_chk: assert property (@(posedge clk) !rst_n |=> result == '0);

   // R5
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(op_sel) == 2'd3) |-> result == '0);

   // R2
   flip_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(op_sel) == 2'd0) |-> $countones(result) == $countones($past(opnd_a)));

   // R7
   ident_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(op_sel) == 2'd1 && $past(opnd_a) == IDENT) |-> result == $past(opnd_b));

   // R7
   ident_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(op_sel) == 2'd2 && $past(opnd_a) == IDENT) |-> result == $past(opnd_b));

   // R3
   or_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(op_sel) == 2'd1 && $past(opnd_b) == '0) |-> result == '0);

   // R4
   xor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(op_sel) == 2'd2 && $past(opnd_a) == '0) |-> result == '0);
endmodule

bind bitmat_unit bitmat_unit_chk #(.DIM(DIM)) i_chk (
   .clk(clk), .rst_n(rst_n), .op_sel(op_sel),
   .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result)
);

// File: tb/test_bitmat_unit.sv
`timescale 1ns/1ps
module test_bitmat_unit;
   localparam int DIM = 8;
   localparam int W   = DIM * DIM;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   op_sel = 2'd0;
   logic [W-1:0] opnd_a = '0;
   logic [W-1:0] opnd_b = '0;
   logic [W-1:0] result;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [W-1:0] exp_q[$];
   string        tag_q[$];

   always #2.5 clk = ~clk;

   bitmat_unit #(.DIM(DIM)) i_bitmat_unit (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result)
   );

   function automatic logic [W-1:0] model(input logic [1:0] op,
                                          input logic [W-1:0] a,
                                          input logic [W-1:0] b);
      logic [W-1:0] m = '0;
      for (int i = 0; i < W; i++) begin
         int r = i / DIM;
         int c = i % DIM;
         int cnt = 0;
         for (int k = 0; k < DIM; k++)
            if (a[r*DIM+k] && b[k*DIM+c]) cnt++;
         case (op)
            2'd0: m[c*DIM+r] = a[r*DIM+c];
            2'd1: m[i] = (cnt != 0);
            2'd2: m[i] = cnt[0];
            default: m[i] = 1'b0;
         endcase
      end
      return m;
   endfunction

   task automatic check(input logic [W-1:0] got, input logic [W-1:0] exp, input string tag);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: result=%h expected=%h", tag, got, exp);
      end
   endtask

   // Called at a falling edge: check the previous vector, then drive a new one.
   task automatic step(input logic [1:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input string tag);
      @(negedge clk);
      if (exp_q.size() > 0) check(result, exp_q.pop_front(), tag_q.pop_front());
      op_sel = op; opnd_a = a; opnd_b = b;
      exp_q.push_back(model(op, a, b));
      tag_q.push_back(tag);
   endtask

   task automatic drain();
      @(negedge clk);
      while (exp_q.size() > 0) check(result, exp_q.pop_front(), tag_q.pop_front());
   endtask

   function automatic logic [W-1:0] rnd64();
      return {$urandom(), $urandom()};
   endfunction

   logic [W-1:0] ident_m;

   initial begin
      ident_m = '0;
      for (int k = 0; k < DIM; k++) ident_m[k*DIM+k] = 1'b1;

      // R6: reset state with busy inputs
      op_sel = 2'd1; opnd_a = '1; opnd_b = '1;
      repeat (3) @(negedge clk);
      check(result, '0, "R6 reset");
      rst_n = 1'b1;
      op_sel = 2'd2; opnd_a = 64'h00000000000000FF; opnd_b = 64'h0101010101010101;
      exp_q.push_back(64'h0); tag_q.push_back("R4 full row x full column even");

      // R3 full row meets full column
      step(2'd1, 64'hFFFFFFFFFFFFFFFF, 64'h0101010101010101, "R3 or full");
      check(model(2'd1, 64'hFFFFFFFFFFFFFFFF, 64'h0101010101010101),
            64'h0101010101010101, "R3 model sanity");
      // R3 single element of B
      step(2'd1, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000001, "R3 single element");
      // R2 row 0 becomes column 0; R1 layout
      step(2'd0, 64'h00000000000000FF, 64'h0, "R2 R1 row to column");
      check(model(2'd0, 64'h00000000000000FF, 64'h0), 64'h0101010101010101, "R1 layout");
      // R8 B ignored in flip
      step(2'd0, 64'h0123456789ABCDEF, 64'hFFFFFFFFFFFFFFFF, "R8 flip b ones");
      step(2'd0, 64'h0123456789ABCDEF, 64'h0, "R8 flip b zero");
      // R5 reserved code
      step(2'd3, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, "R5 reserved");
      // R7 identity
      step(2'd1, ident_m, 64'hDEADBEEFCAFEF00D, "R7 identity or");
      step(2'd2, ident_m, 64'h0F1E2D3C4B5A6978, "R7 identity xor");
      drain();
      check(model(2'd2, ident_m, 64'h0F1E2D3C4B5A6978), 64'h0F1E2D3C4B5A6978, "R7 model sanity");

      // Random back-to-back, every code in turn
      for (int n = 0; n < 400; n++) begin
         logic [1:0] op = 2'(n % 4);
         string t;
         case (op)
            2'd0: t = "R2 random flip";
            2'd1: t = "R3 random or";
            2'd2: t = "R4 random xor";
            default: t = "R5 random reserved";
         endcase
         step(op, rnd64(), rnd64(), t);
      end
      for (int n = 0; n < 40; n++) begin
         logic [W-1:0] bb = rnd64();
         step(2'(1 + (n % 2)), ident_m, bb, "R7 random identity");
      end
      drain();

      // R6: reset mid-stream clears the register
      @(negedge clk);
      op_sel = 2'd1; opnd_a = '1; opnd_b = '1; rst_n = 1'b0;
      @(negedge clk);
      check(result, '0, "R6 reset mid-stream");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #50000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: result=%h expected=completion", result);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule